// File: doc/BRIEF.md
# SPI Serial EEPROM Device Model

This block is the device end of a serial memory that a host reaches over a mode-0 SPI link. It keeps 512 bytes in an on-chip register array that comes out of reset erased to 0xFF. The host drives a clock, an active-low select and a data line. The block returns bytes on a serial output. A separate enable output shows when that serial output is actively driven. All four link signals pass through two-flop synchronisers and are handled in the system clock domain. The link therefore has to run several times slower than the system clock.

Every command begins with an 8-bit instruction byte, sent MSB first. For array accesses the ninth address bit rides in bit 3 of that byte. Reads stream bytes for as long as the host keeps clocking. Writes need a write-enable latch, and they collect up to four bytes that stay inside one four-byte page. A write reaches the array only if select rises on one of the legal clock counts. Each committed write, whether to the array or to the status register, occupies a busy window of `WRITE_CYCLES` system clocks. The busy flag reads 1 during that window, and only status reads are obeyed.

Top module: `spi_eeprom`

## Requirements
- R1: After reset the status byte reads 0x00, the output enable is low and every array byte reads 0xFF.
- R2: SI is sampled on rising SCK and SO changes after falling SCK, with all bytes sent MSB first.
- R3: READ (0000_A011, where bit 3 is address bit 8) followed by an address byte streams data from that address. The address advances after each byte and wraps from 0x1FF to 0x000.
- R4: RDSR (0x05) returns the status byte {user[5:0], WEL at bit 1, WIP at bit 0}, repeated for each further byte clocked.
- R5: WREN (0x06) sets WEL only when select rises after exactly 8 clocks. If more clocks follow, WEL stays clear and a later write is ignored.
- R6: WRDI (0x04) clears WEL.
- R7: WRITE (0000_A010, where bit 3 is address bit 8) leaves the array unchanged when WEL is clear.
- R8: A page write stores 1 to 4 bytes. The low two address bits step and wrap from 11 to 00 while the upper bits hold, and bytes of the page that were not sent keep their old values.
- R9: A WRITE is committed only when select rises after 24, 32, 40 or 48 clocks. At any other count the array and WEL are unchanged.
- R10: A commit raises WIP (status bit 0) for WRITE_CYCLES system clocks.
- R11: While WIP is 1, every instruction other than RDSR is ignored, so a READ never enables SO.
- R12: When the write window ends, WEL is cleared.
- R13: WRSR (0x01) with WEL set and select rising after exactly 16 clocks writes data bits [7:2] into status bits [7:2] and starts a write window. Otherwise the status byte is unchanged.
- R14: The output enable is high only while read data or status bits are being shifted out, and it drops when select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, the power-on event |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| soEn | output | 1 | High while `so` is actively driven |

## Verification
A wrong bit count or decoder state shows up on the very next select rise. A write then lands when it should not, or is lost when it should land, and the next readback of that page exposes it within a few hundred system clocks. A stuck or wrongly cleared write-enable or busy flag appears in the status byte on the following RDSR. A wrong page pointer shows up as bytes placed at rotated positions inside the page. A wrong stream address shows up as a skipped or repeated byte at the array end.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam int ADDR_W     = 9;
  localparam int PAGE_W     = 2;
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = 7;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef struct packed {
    logic              loadAddr;
    logic              incAddr;
    logic              incPage;
    logic              bufWrite;
    logic              loadStat;
    logic              shiftOut;
    logic              commit;
    logic [ADDR_W-1:0] addrVal;
    logic [7:0]        data;
    logic [7:0]        stat;
  } dpCtrl_t;
endpackage

// File: rtl/spi_eeprom_dp.sv
module spi_eeprom_dp
  import spi_eeprom_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t strb,
  output logic    soBit
);
  logic [7:0]            mem [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [ADDR_W-1:0]     addr;
  logic [ADDR_W-1:0]     nextAddr;
  logic [7:0]            outShift;

  assign nextAddr = addr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'h00;
      mask     <= '0;
      addr     <= '0;
      outShift <= '0;
      soBit    <= 1'b0;
    end else begin
      if (strb.loadAddr) begin
        addr     <= strb.addrVal;
        outShift <= mem[strb.addrVal];
        mask     <= '0;
      end else if (strb.incAddr) begin
        addr     <= nextAddr;
        outShift <= mem[nextAddr];
      end else if (strb.incPage) begin
        addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
      end
      if (strb.bufWrite) begin
        pageBuf[addr[PAGE_W-1:0]] <= strb.data;
        mask[addr[PAGE_W-1:0]]    <= 1'b1;
      end
      if (strb.loadStat) outShift <= strb.stat;
      if (strb.shiftOut) begin
        soBit    <= outShift[7];
        outShift <= {outShift[6:0], 1'b0};
      end
      if (strb.commit) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (mask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  // R8
  commit_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (mask != '0));
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sckIn,
  input  logic    csNIn,
  input  logic    siIn,
  output logic    soEn,
  output dpCtrl_t strb
);
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [3:0] {
    S_OPC, S_WREN, S_RADR, S_RDAT, S_STAT, S_WADR, S_WDAT, S_WSR, S_WSRD, S_IGN
  } state_t;

  state_t            st;
  logic [1:0]        sckSync, csSync, siSync;
  logic              sckPrev, csPrev;
  logic              sck, cs, si;
  logic              sckRise, sckFall, csRise, byteEnd;
  logic [CNT_W-1:0]  bitCnt;
  logic [6:0]        inByte;
  logic [7:0]        newByte;
  logic              a8, wel, wip;
  logic [5:0]        usrBits, srPend;
  logic [BUSY_W-1:0] busyCnt;
  logic              opRead, opWrite, legalEnd, srCommit;

  assign sck      = sckSync[1];
  assign cs       = csSync[1];
  assign si       = siSync[1];
  assign sckRise  = sck & ~sckPrev & ~cs;
  assign sckFall  = ~sck & sckPrev & ~cs;
  assign csRise   = cs & ~csPrev;
  assign newByte  = {inByte, si};
  assign byteEnd  = sckRise && (bitCnt[2:0] == 3'd7);
  assign wip      = (busyCnt != '0);
  assign opRead   = (newByte[7:4] == 4'h0) && (newByte[2:0] == 3'b011);
  assign opWrite  = (newByte[7:4] == 4'h0) && (newByte[2:0] == 3'b010);
  assign legalEnd = (bitCnt == 7'd24) || (bitCnt == 7'd32) ||
                    (bitCnt == 7'd40) || (bitCnt == 7'd48);
  assign srCommit = csRise && (st == S_WSRD) && (bitCnt == 7'd16);

  always_comb begin
    strb          = '0;
    strb.addrVal  = {a8, newByte};
    strb.data     = newByte;
    strb.stat     = {usrBits, wel, wip};
    strb.shiftOut = sckFall && ((st == S_RDAT) || (st == S_STAT));
    strb.commit   = csRise && (st == S_WDAT) && legalEnd;
    if (byteEnd) begin
      case (st)
        S_OPC:  strb.loadStat = (newByte == OP_RDSR);
        S_STAT: strb.loadStat = 1'b1;
        S_RADR: strb.loadAddr = 1'b1;
        S_WADR: strb.loadAddr = 1'b1;
        S_RDAT: strb.incAddr  = 1'b1;
        S_WDAT: begin
          strb.bufWrite = 1'b1;
          strb.incPage  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= 2'b00;
      csSync  <= 2'b11;
      siSync  <= 2'b00;
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
      st      <= S_OPC;
      bitCnt  <= '0;
      inByte  <= '0;
      a8      <= 1'b0;
      wel     <= 1'b0;
      usrBits <= '0;
      srPend  <= '0;
      busyCnt <= '0;
      soEn    <= 1'b0;
    end else begin
      sckSync <= {sckSync[0], sckIn};
      csSync  <= {csSync[0], csNIn};
      siSync  <= {siSync[0], siIn};
      sckPrev <= sck;
      csPrev  <= cs;
      if (wip) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == BUSY_W'(1)) wel <= 1'b0;
      end
      if (cs) begin
        st     <= S_OPC;
        bitCnt <= '0;
        soEn   <= 1'b0;
        if (csRise && (st == S_WREN) && (bitCnt == 7'd8)) wel <= 1'b1;
        if (strb.commit || srCommit) busyCnt <= BUSY_W'(WRITE_CYCLES);
        if (srCommit) usrBits <= srPend;
      end else begin
        if (strb.shiftOut) soEn <= 1'b1;
        if (sckRise) begin
          if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
          inByte <= newByte[6:0];
        end
        if (byteEnd) begin
          case (st)
            S_OPC: begin
              if (wip && (newByte != OP_RDSR)) st <= S_IGN;
              else if (newByte == OP_WREN) st <= S_WREN;
              else if (newByte == OP_WRDI) begin
                wel <= 1'b0;
                st  <= S_IGN;
              end
              else if (newByte == OP_RDSR) st <= S_STAT;
              else if (newByte == OP_WRSR) st <= wel ? S_WSR : S_IGN;
              else if (opRead) begin
                a8 <= newByte[3];
                st <= S_RADR;
              end
              else if (opWrite) begin
                a8 <= newByte[3];
                st <= wel ? S_WADR : S_IGN;
              end
              else st <= S_IGN;
            end
            S_WREN: st <= S_IGN;
            S_RADR: st <= S_RDAT;
            S_WADR: st <= S_WDAT;
            S_WSR: begin
              srPend <= newByte[7:2];
              st     <= S_WSRD;
            end
            S_WSRD: st <= S_IGN;
            default: ;
          endcase
        end
      end
    end
  end

  // R14
  out_en_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    soEn |-> ((st == S_RDAT) || (st == S_STAT)));
  // R5
  wel_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(csRise));
  // R12
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);
  // R11
  no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !strb.commit);
  // R10
  wip_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(strb.commit || srCommit));
endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
  import spi_eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic si,
  output logic so,
  output logic soEn
);
  dpCtrl_t strb;

  spi_eeprom_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sckIn (sck),
    .csNIn (csN),
    .siIn  (si),
    .soEn  (soEn),
    .strb  (strb)
  );

  spi_eeprom_dp uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .soBit (so)
  );
endmodule

// File: tb/tb_spi_eeprom.sv
module tb_spi_eeprom;
  localparam int WC   = 1000;
  localparam int HALF = 8;

  typedef struct packed {
    logic [8:0]  addr;
    logic [2:0]  n;
    logic [31:0] data;
  } wvec_t;

  localparam wvec_t VEC [5] = '{
    '{9'h010, 3'd1, 32'hA5000000},
    '{9'h122, 3'd4, 32'h11223344},
    '{9'h1FC, 3'd4, 32'hDEADBEEF},
    '{9'h085, 3'd2, 32'h5A3C0000},
    '{9'h0FF, 3'd3, 32'h01020300}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic si = 1'b0;
  logic so, soEn;
  int   errs = 0;
  int   checks = 0;
  logic [7:0] model [512];
  logic [7:0] rx [4];
  logic [7:0] st, junk;

  always #5 clk = ~clk;

  spi_eeprom #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .so(so), .soEn(soEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xferN(input logic [7:0] tx, input int n, output logic [7:0] rxb);
    rxb = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      tick(HALF);
      rxb[i] = so;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb);
    xferN(tx, 8, rxb);
  endtask

  task automatic csLow();
    csN = 1'b0;
    tick(HALF);
  endtask

  task automatic csHigh();
    tick(HALF);
    csN = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    csLow();
    xfer(op, junk);
    csHigh();
  endtask

  task automatic rdsr(output logic [7:0] s);
    csLow();
    xfer(8'h05, junk);
    xfer(8'h00, s);
    csHigh();
  endtask

  task automatic wrBytes(input logic [8:0] a, input int n, input logic [31:0] d);
    csLow();
    xfer({4'b0000, a[8], 3'b010}, junk);
    xfer(a[7:0], junk);
    for (int i = 0; i < n; i++) xfer(d[31 - 8*i -: 8], junk);
    csHigh();
  endtask

  task automatic modelWrite(input logic [8:0] a, input int n, input logic [31:0] d);
    for (int i = 0; i < n; i++)
      model[{a[8:2], 2'(a[1:0] + 2'(i))}] = d[31 - 8*i -: 8];
  endtask

  task automatic rdBytes(input logic [8:0] a, input int n);
    csLow();
    xfer({4'b0000, a[8], 3'b011}, junk);
    xfer(a[7:0], junk);
    for (int i = 0; i < n; i++) xfer(8'h00, rx[i]);
    csHigh();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1 reset state
    check({7'b0, soEn}, 8'h00, "R1 soEn");
    rdsr(st);
    check(st, 8'h00, "R1 status");
    rdBytes(9'h000, 1);
    check(rx[0], 8'hFF, "R1 erased");

    // Table: page writes then readback of the whole page (R2 R3 R8 R9 R12)
    for (int v = 0; v < 5; v++) begin
      cmd1(8'h06);
      wrBytes(VEC[v].addr, int'(VEC[v].n), VEC[v].data);
      modelWrite(VEC[v].addr, int'(VEC[v].n), VEC[v].data);
      tick(WC + 200);
      rdBytes({VEC[v].addr[8:2], 2'b00}, 4);
      for (int i = 0; i < 4; i++)
        check(rx[i], model[{VEC[v].addr[8:2], 2'(i)}], "R2 R8 page readback");
      rdsr(st);
      check(st, 8'h00, "R12 WEL cleared after write");
    end

    // R3 stream wraps from 0x1FF to 0x000
    rdBytes(9'h1FE, 4);
    check(rx[0], model[9'h1FE], "R3 wrap byte0");
    check(rx[1], model[9'h1FF], "R3 wrap byte1");
    check(rx[2], model[9'h000], "R3 wrap byte2");
    check(rx[3], model[9'h001], "R3 wrap byte3");

    // R4 status repeats; R14 enable high while shifting, low after select rises
    cmd1(8'h06);
    csLow();
    xfer(8'h05, junk);
    xfer(8'h00, rx[0]);
    xfer(8'h00, rx[1]);
    check({7'b0, soEn}, 8'h01, "R14 enable while shifting");
    csHigh();
    check(rx[0], 8'h02, "R4 status first");
    check(rx[1], 8'h02, "R4 status repeat");
    check({7'b0, soEn}, 8'h00, "R14 enable after select high");

    // R6 WRDI clears WEL
    cmd1(8'h04);
    rdsr(st);
    check(st, 8'h00, "R6 WRDI");

    // R7 write without WEL ignored
    wrBytes(9'h050, 1, 32'h77000000);
    tick(WC + 200);
    rdBytes(9'h050, 1);
    check(rx[0], 8'hFF, "R7 write without WEL");

    // R5 WREN followed by more clocks is not honoured
    csLow();
    xfer(8'h06, junk);
    xfer(8'h00, junk);
    csHigh();
    rdsr(st);
    check(st, 8'h00, "R5 WREN with extra clocks");
    wrBytes(9'h040, 1, 32'h77000000);
    tick(WC + 200);
    rdBytes(9'h040, 1);
    check(rx[0], 8'hFF, "R5 later write ignored");

    // R9 select rises at 28 clocks: discarded, WEL kept
    cmd1(8'h06);
    csLow();
    xfer(8'h02, junk);
    xfer(8'h60, junk);
    xfer(8'h99, junk);
    xferN(8'hF0, 4, junk);
    csHigh();
    tick(WC + 200);
    rdBytes(9'h060, 1);
    check(rx[0], 8'hFF, "R9 odd count discarded");
    rdsr(st);
    check(st, 8'h02, "R9 WEL kept");
    cmd1(8'h04);

    // R10 WIP visible; R11 READ ignored while busy
    cmd1(8'h06);
    wrBytes(9'h070, 1, 32'h3C000000);
    rdsr(st);
    check({7'b0, st[0]}, 8'h01, "R10 WIP set");
    csLow();
    xfer(8'h03, junk);
    xfer(8'h70, junk);
    xfer(8'h00, junk);
    check({7'b0, soEn}, 8'h00, "R11 READ while busy");
    csHigh();
    tick(WC + 200);
    rdsr(st);
    check(st, 8'h00, "R12 idle after window");
    rdBytes(9'h070, 1);
    check(rx[0], 8'h3C, "R10 committed byte");

    // R13 status write rules
    cmd1(8'h06);
    csLow();
    xfer(8'h01, junk);
    xfer(8'hF3, junk);
    csHigh();
    tick(WC + 200);
    rdsr(st);
    check(st, 8'hF0, "R13 WRSR stored");
    csLow();
    xfer(8'h01, junk);
    xfer(8'h0C, junk);
    csHigh();
    tick(WC + 200);
    rdsr(st);
    check(st, 8'hF0, "R13 WRSR without WEL");
    cmd1(8'h06);
    csLow();
    xfer(8'h01, junk);
    xfer(8'h30, junk);
    xfer(8'h00, junk);
    csHigh();
    tick(WC + 200);
    rdsr(st);
    check(st, 8'hF2, "R13 WRSR bad count");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule